// File: doc/BRIEF.md
# Bit-Addressable Output Bank with Demultiplex Mode

This block holds a bank of eight output bits that are written one at a time by address. A 3-bit select picks the target bit and a single data line supplies the value. Two active-low control lines pick one of four modes: write one bit, hold everything, steer the data bit to the selected output while driving all others low, or clear the whole bank. Typical uses are fanning out individual control strobes or enables from a narrow write path, and producing a one-hot pulse pattern.

The design is fully synchronous. The mode, select and data inputs are sampled at each rising clock edge, and the outputs come straight from registers. A separate asynchronous active-low power-on reset clears the bank. Its release is synchronized to the clock, so the bank accepts its first update on the third rising edge after the reset input goes high.

Top module: `bit_addr_bank`

## Requirements
- R1: With `wr_en_n`=0 and `mclr_n`=1 (write mode), the output selected by `sel` takes the value of `din` at the next rising edge.
- R2: In write mode, every output not selected by `sel` keeps its value across the edge.
- R3: With `wr_en_n`=1 and `mclr_n`=1 (hold mode), all outputs keep their values whatever `sel` and `din` do.
- R4: With `wr_en_n`=0 and `mclr_n`=0 (demux mode), after the edge the selected output equals `din` and every other output is 0.
- R5: With `wr_en_n`=1 and `mclr_n`=0 (clear mode), all outputs are 0 after the edge, whatever `sel` and `din` are.
- R6: `sel` is unsigned binary with bit 0 as the least significant bit. A value of k selects `q[k]`, so 0 selects `q[0]` and 7 selects `q[7]`.
- R7: The pattern left by demux or clear mode is the stored state. A following hold keeps that one-hot or all-zero pattern, and a following write changes only the selected bit of it.
- R8: `rst_n`=0 clears all outputs at once without a clock edge. After `rst_n` rises, the first two rising edges leave the outputs at 0 in every mode, and the third edge applies the mode normally.
- R9: Outputs change only on a rising clock edge. An input change between edges has no effect on `q` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low, release synchronized inside |
| wr_en_n | input | 1 | Active-low enable; together with `mclr_n` it selects the mode |
| mclr_n | input | 1 | Active-low mode clear; together with `wr_en_n` it selects the mode |
| sel | input | 3 | Binary index of the target output bit |
| din | input | 1 | Data bit for write and demux modes |
| q | output | 8 | Registered output bank |

## Verification
The bench visits all eight select values in every mode. A decoder with swapped or mirrored select bits would therefore land writes on the wrong output. It steps from demux and from clear into hold and then into write, which exposes a design that keeps a shadow copy of the old contents or restores it after the demux pattern. It changes select and data repeatedly while in hold, so any leak of those inputs into the bank would show as a changed output. It also asserts the power-on reset between edges and counts the two dead edges after release, which catches a reset that waits for the clock or a release that is not synchronized.

// File: rtl/abank_pkg.sv
package abank_pkg;

  // Mode code is the concatenation {wr_en_n, mclr_n}.
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } abank_mode_e;

endpackage

// File: rtl/abank_rst_sync.sv
module abank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/abank_mode_dec.sv
module abank_mode_dec
  import abank_pkg::*;
(
  input  logic        wr_en_n,
  input  logic        mclr_n,
  output abank_mode_e mode
);

  always_comb begin
    mode = abank_mode_e'({wr_en_n, mclr_n});
  end

endmodule

// File: rtl/abank_sel_dec.sv
module abank_sel_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel,
  output logic [NBITS-1:0]  hit
);

  for (genvar g = 0; g < NBITS; g++) begin : g_hit
    assign hit[g] = (sel == ADDR_W'(g));
  end

endmodule

// File: rtl/abank_cell_bank.sv
module abank_cell_bank
  import abank_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  abank_mode_e      mode,
  input  logic [NBITS-1:0] hit,
  input  logic             din,
  output logic [NBITS-1:0] q
);

  logic [NBITS-1:0] bit_ce;
  logic [NBITS-1:0] bit_d;

  for (genvar g = 0; g < NBITS; g++) begin : g_cell
    // Next-state and clock enable for one cell
    always_comb begin
      bit_ce[g] = 1'b0;
      bit_d[g]  = 1'b0;
      unique case (mode)
        MODE_WRITE: begin
          bit_ce[g] = hit[g];
          bit_d[g]  = din;
        end
        MODE_DEMUX: begin
          bit_ce[g] = 1'b1;
          bit_d[g]  = hit[g] & din;
        end
        MODE_CLEAR: begin
          bit_ce[g] = 1'b1;
          bit_d[g]  = 1'b0;
        end
        default: begin
          bit_ce[g] = 1'b0;
          bit_d[g]  = 1'b0;
        end
      endcase
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)        q[g] <= 1'b0;
      else if (bit_ce[g]) q[g] <= bit_d[g];
    end
  end

  // R1: the selected cell lands on the sampled data
  a_r1_write_target: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_WRITE) |=> ((q & $past(hit)) == ($past(din) ? $past(hit) : '0)));

  // R2: cells outside the selection are untouched by a write
  a_r2_write_others: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_WRITE) |=> ((q & ~$past(hit)) == ($past(q) & ~$past(hit))));

  // R3: hold freezes the bank
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_HOLD) |=> $stable(q));

  // R4: demux leaves at most the selected bit set
  a_r4_demux_onehot: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_DEMUX) |=> ($onehot0(q) && ((q & ~$past(hit)) == '0)));

  // R5: clear empties the bank
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == MODE_CLEAR) |=> (q == '0));

endmodule

// File: rtl/bit_addr_bank.sv
module bit_addr_bank
  import abank_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NBITS      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              mclr_n,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  output logic [NBITS-1:0]  q
);

  logic        srst_n;
  abank_mode_e mode;
  logic [NBITS-1:0] hit;

  abank_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  abank_mode_dec u_mode_dec (
    .wr_en_n (wr_en_n),
    .mclr_n  (mclr_n),
    .mode    (mode)
  );

  abank_sel_dec #(.ADDR_W(ADDR_W)) u_sel_dec (
    .sel (sel),
    .hit (hit)
  );

  abank_cell_bank #(.NBITS(NBITS)) u_cells (
    .clk    (clk),
    .srst_n (srst_n),
    .mode   (mode),
    .hit    (hit),
    .din    (din),
    .q      (q)
  );

  // R6: every select value picks exactly one cell
  a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot(hit));

  // R8: while the synchronized reset is low the bank reads zero
  a_r8_reset_clear: assert property (@(posedge clk)
    (!srst_n) |-> (q == '0));

endmodule

// File: tb/bit_addr_bank_tb.sv
module bit_addr_bank_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en_n;
  logic       mclr_n;
  logic [2:0] sel;
  logic       din;
  logic [7:0] q;

  int n_chk;
  int n_bad;
  logic [7:0] ref_q;

  bit_addr_bank u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_n (wr_en_n),
    .mclr_n  (mclr_n),
    .sel     (sel),
    .din     (din),
    .q       (q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector layout: {wr_en_n, mclr_n, sel[2:0], din, expected q[7:0]}
  // Modes: 01 write, 11 hold, 00 demux, 10 clear
  localparam logic [13:0] VEC [18] = '{
    {2'b01, 3'd3, 1'b1, 8'h08},
    {2'b01, 3'd7, 1'b1, 8'h88},
    {2'b01, 3'd0, 1'b1, 8'h89},
    {2'b01, 3'd3, 1'b0, 8'h81},
    {2'b11, 3'd5, 1'b1, 8'h81},
    {2'b11, 3'd0, 1'b0, 8'h81},
    {2'b00, 3'd2, 1'b1, 8'h04},
    {2'b11, 3'd6, 1'b1, 8'h04},
    {2'b01, 3'd6, 1'b1, 8'h44},
    {2'b00, 3'd5, 1'b0, 8'h00},
    {2'b11, 3'd1, 1'b1, 8'h00},
    {2'b01, 3'd1, 1'b1, 8'h02},
    {2'b01, 3'd4, 1'b1, 8'h12},
    {2'b10, 3'd4, 1'b1, 8'h00},
    {2'b11, 3'd2, 1'b1, 8'h00},
    {2'b01, 3'd5, 1'b1, 8'h20},
    {2'b00, 3'd7, 1'b1, 8'h80},
    {2'b10, 3'd7, 1'b1, 8'h00}
  };

  function automatic logic [7:0] model(logic [7:0] cur, logic [1:0] md,
                                       logic [2:0] s, logic d);
    logic [7:0] nx;
    nx = cur;
    case (md)
      2'b01: nx[s] = d;
      2'b00: begin nx = 8'h00; nx[s] = d; end
      2'b10: nx = 8'h00;
      default: nx = cur;
    endcase
    return nx;
  endfunction

  task automatic check(string req, logic [7:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, checks at next falling edge
  task automatic step(logic [1:0] md, logic [2:0] s, logic d);
    {wr_en_n, mclr_n} = md;
    sel = s;
    din = d;
    ref_q = model(ref_q, md, s, d);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    rst_n   = 1'b0;
    wr_en_n = 1'b1;
    mclr_n  = 1'b1;
    sel     = 3'd0;
    din     = 1'b0;
    ref_q   = 8'h00;

    repeat (3) @(negedge clk);
    check("R8 reset state", 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 idle after release", 8'h00);

    // Table walk (R1..R7)
    foreach (VEC[i]) begin
      step(VEC[i][13:12], VEC[i][11:9], VEC[i][8]);
      check($sformatf("R1/R2/R3/R4/R5/R7 vector %0d", i), VEC[i][7:0]);
    end
    ref_q = 8'h00;

    // R6 + R1 + R2: set each bit by address, then clear each
    for (int a = 0; a < 8; a++) begin
      step(2'b01, 3'(a), 1'b1);
      check($sformatf("R6 R1 set sel=%0d", a), ref_q);
    end
    check("R1 all set", 8'hFF);
    for (int a = 0; a < 8; a++) begin
      step(2'b01, 3'(a), 1'b0);
      check($sformatf("R2 clear sel=%0d", a), ref_q);
    end

    // R3: hold under every select/data combination
    step(2'b01, 3'd2, 1'b1);
    step(2'b01, 3'd5, 1'b1);
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        step(2'b11, 3'(a), 1'(d));
        check($sformatf("R3 hold sel=%0d din=%0d", a, d), 8'h24);
      end
    end

    // R4 + R7: demux at every address, then hold and write on top
    for (int a = 0; a < 8; a++) begin
      step(2'b00, 3'(a), 1'b1);
      check($sformatf("R4 demux sel=%0d", a), 8'(1 << a));
      step(2'b11, 3'(7 - a), 1'b0);
      check($sformatf("R7 hold after demux sel=%0d", a), 8'(1 << a));
      step(2'b01, 3'((a + 3) % 8), 1'b1);
      check($sformatf("R7 write after demux sel=%0d", a), ref_q);
    end
    for (int a = 0; a < 8; a++) begin
      step(2'b01, 3'((a + 1) % 8), 1'b1);
      step(2'b00, 3'(a), 1'b0);
      check($sformatf("R4 demux din=0 sel=%0d", a), 8'h00);
    end

    // R5 + R7: clear at every address and data value
    for (int a = 0; a < 8; a++) begin
      step(2'b01, 3'(a), 1'b1);
      step(2'b10, 3'(a), 1'(a % 2));
      check($sformatf("R5 clear sel=%0d", a), 8'h00);
      step(2'b11, 3'(a), 1'b1);
      check($sformatf("R7 hold after clear sel=%0d", a), 8'h00);
    end

    // R9: no change between edges
    step(2'b01, 3'd1, 1'b1);
    {wr_en_n, mclr_n} = 2'b01; sel = 3'd6; din = 1'b1;
    #3;
    check("R9 no change before edge", 8'h02);
    ref_q = model(ref_q, 2'b01, 3'd6, 1'b1);
    @(negedge clk);
    check("R9 change after edge", 8'h42);

    // R8: asynchronous clear mid-cycle, synchronized release
    {wr_en_n, mclr_n} = 2'b11;
    #3;
    rst_n = 1'b0;
    #2;
    check("R8 async clear without edge", 8'h00);
    @(negedge clk);
    {wr_en_n, mclr_n} = 2'b01; sel = 3'd4; din = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 first edge after release", 8'h00);
    @(negedge clk);
    check("R8 second edge after release", 8'h00);
    @(negedge clk);
    check("R8 third edge applies write", 8'h10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule